// File: doc/BRIEF.md
# Rewind interrupt pending arbiter

This block collects the interrupt requests of a tape controller that serves eight drives. Each drive can report that a rewind has finished. When the command that started the rewind asked for an interrupt, a pending bit is kept for that drive. The controller itself can raise one interrupt of its own, tagged with the unit it concerns. A single level output tells the processor that something is waiting.

When the processor acknowledges, the block picks one source and clears it. The controller interrupt is served first. Otherwise the lowest-numbered drive with a pending rewind bit is served. The block returns a registered response word that holds three things: the unit number, a flag telling a drive interrupt from a controller interrupt, and the error-type bits of that unit's status.

A halt aimed at one unit withdraws that unit's pending interrupts and emits a pulse that cancels its rewind in progress. A finished rewind always emits a per-unit begin-of-tape pulse for the drive logic, whether or not an interrupt was wanted. Timing the rewind itself is left to the drive logic. The asynchronous reset is released through a two-stage synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `rwint_arbiter`

## Requirements
- R1: While reset is active and after it is released, nothing is pending: `irq_pend`, `resp`, `resp_valid`, `bot_set` and `rew_cancel` are all 0. Reset asserted in the middle of operation drops `irq_pend` at once.
- R2: A pulse on `rew_done[u]` gives a one-cycle pulse on `bot_set[u]` one clock later. A pending bit is set for unit u only if `rew_irq_want[u]` is high in the same cycle.
- R3: `irq_pend` is high exactly while the controller interrupt or at least one rewind bit is pending. It rises in the cycle after the setting event. After an acknowledge it stays high if anything still remains pending.
- R4: An `ack` pulse gives `resp_valid` high for exactly one cycle, one clock later, with the new `resp`. `resp` keeps its value between acknowledges.
- R5: A pending controller interrupt wins over all rewind bits. Its response carries the controller unit number in `resp[10:8]` with bit 6 at 0, and the controller interrupt is cleared.
- R6: With no controller interrupt pending, the lowest-numbered pending rewind unit is cleared and returned in `resp[10:8]` with bit 6 at 1.
- R7: `resp[7:0]` holds the selected unit's `dev_status` byte ANDed with 8'hB8 (bits 7, 5, 4, 3), ORed with the flag in bit 6. Bits 2:0 are always 0.
- R8: An acknowledge with nothing pending returns an all-zero response, with `resp_valid` still pulsed.
- R9: `halt` with `halt_unit` = u clears unit u's rewind bit. It also clears the controller interrupt if that interrupt belongs to unit u. One clock later it pulses `rew_cancel[u]`.
- R10: In the same cycle, a halt of unit u suppresses a concurrent `rew_done[u]`: no pending bit is set and no `bot_set` pulse is produced. A new rewind or controller request in the same cycle as an acknowledge that clears the same source leaves that source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rew_done | input | 8 | Per-unit rewind-finished strobe |
| rew_irq_want | input | 8 | Per-unit qualifier: the rewind asked for an interrupt |
| ctl_irq_set | input | 1 | Raise the controller interrupt |
| ctl_irq_unit | input | 3 | Unit tagged to the controller interrupt |
| ack | input | 1 | Interrupt acknowledge strobe |
| halt | input | 1 | Halt strobe |
| halt_unit | input | 3 | Unit addressed by the halt |
| dev_status | input | 64 | Status byte of each unit, unit u in bits [8u+7:8u] |
| irq_pend | output | 1 | Interrupt pending level |
| resp | output | 11 | Acknowledge response: unit in [10:8], drive flag in bit 6, masked status |
| resp_valid | output | 1 | One-cycle strobe marking a new response |
| bot_set | output | 8 | Per-unit begin-of-tape pulse after a finished rewind |
| rew_cancel | output | 8 | Per-unit pulse cancelling a rewind in progress |

## Verification
Two pairs of functions can land in the same cycle. The first is a halt and a finished rewind on the same unit. The bench provokes it by pulsing `halt` and `rew_done` on one unit in one cycle, then judges the result at the ports: `irq_pend` must stay low, `bot_set` must stay quiet, and a later acknowledge must return all zeros. The second is an acknowledge together with a new request for the source it clears. The bench pulses `ack` with `rew_done` on unit 0, then expects `irq_pend` to stay high and a second acknowledge to return unit 0 again.

// File: rtl/rwint_pkg.sv
package rwint_pkg;
  localparam int STAT_W = 8;
  localparam logic [STAT_W-1:0] ACK_STAT_MASK = 8'hB8;
  localparam int DEVFLAG_BIT = 6;

  function automatic logic [STAT_W-1:0] ack_status_byte(
      input logic [STAT_W-1:0] raw, input logic dev_flag);
    logic [STAT_W-1:0] b;
    b = raw & ACK_STAT_MASK;
    b[DEVFLAG_BIT] = dev_flag;
    return b;
  endfunction
endpackage

// File: rtl/rwint_pend_bank.sv
module rwint_pend_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] pend
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic bit_d, bit_q;
    always_comb begin
      bit_d = bit_q;
      if (clr_vec[g]) bit_d = 1'b0;
      if (set_vec[g]) bit_d = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= bit_d;
    end
    assign pend[g] = bit_q;
  end
endmodule

// File: rtl/rwint_prio_pick.sv
module rwint_prio_pick #(
  parameter int N  = 8,
  parameter int UW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [UW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = UW'(i);
    end
    any = |req;
  end
endmodule

// File: rtl/rwint_resp_fmt.sv
module rwint_resp_fmt
  import rwint_pkg::*;
#(
  parameter int N  = 8,
  parameter int UW = 3
) (
  input  logic                  sel_valid,
  input  logic                  sel_is_dev,
  input  logic [UW-1:0]         sel_unit,
  input  logic [N*STAT_W-1:0]   status_all,
  output logic [STAT_W+UW-1:0]  resp_d
);
  logic [STAT_W-1:0] raw;
  always_comb begin
    raw = status_all[sel_unit*STAT_W +: STAT_W];
    if (sel_valid) resp_d = {sel_unit, ack_status_byte(raw, sel_is_dev)};
    else           resp_d = '0;
  end
endmodule

// File: rtl/rwint_arbiter.sv
module rwint_arbiter
  import rwint_pkg::*;
#(
  parameter int N = 8,
  localparam int UW = $clog2(N),
  localparam int RESP_W = STAT_W + UW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        rew_done,
  input  logic [N-1:0]        rew_irq_want,
  input  logic                ctl_irq_set,
  input  logic [UW-1:0]       ctl_irq_unit,
  input  logic                ack,
  input  logic                halt,
  input  logic [UW-1:0]       halt_unit,
  input  logic [N*STAT_W-1:0] dev_status,
  output logic                irq_pend,
  output logic [RESP_W-1:0]   resp,
  output logic                resp_valid,
  output logic [N-1:0]        bot_set,
  output logic [N-1:0]        rew_cancel
);
  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [N-1:0]  halt_dec, rew_set, rew_clr, rew_pend, ack_clr;
  logic          pick_any;
  logic [UW-1:0] pick_idx;
  logic          ctl_pend_q, ctl_pend_d;
  logic [UW-1:0] ctl_unit_q, ctl_unit_d;
  logic          sel_valid;
  logic [UW-1:0] sel_unit;
  logic [RESP_W-1:0] resp_d, resp_q;
  logic          resp_valid_q;
  logic [N-1:0]  bot_q, cancel_q;

  always_comb begin
    halt_dec = '0;
    if (halt) halt_dec[halt_unit] = 1'b1;
    ack_clr = '0;
    if (ack && !ctl_pend_q && pick_any) ack_clr[pick_idx] = 1'b1;
    // halt wins over a new set; a new set wins over the acknowledge clear
    rew_set = rew_done & rew_irq_want & ~halt_dec;
    rew_clr = ack_clr | halt_dec;
  end

  rwint_pend_bank #(.N(N)) u_bank (
    .clk(clk), .rst_n(rst_int_n),
    .set_vec(rew_set), .clr_vec(rew_clr), .pend(rew_pend)
  );

  rwint_prio_pick #(.N(N), .UW(UW)) u_pick (
    .req(rew_pend), .any(pick_any), .idx(pick_idx)
  );

  always_comb begin
    ctl_pend_d = ctl_pend_q;
    ctl_unit_d = ctl_unit_q;
    if (ack && ctl_pend_q) ctl_pend_d = 1'b0;
    if (halt && (halt_unit == ctl_unit_q)) ctl_pend_d = 1'b0;
    if (ctl_irq_set) begin
      ctl_pend_d = 1'b1;
      ctl_unit_d = ctl_irq_unit;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctl_pend_q <= 1'b0;
      ctl_unit_q <= '0;
    end else begin
      ctl_pend_q <= ctl_pend_d;
      ctl_unit_q <= ctl_unit_d;
    end
  end

  always_comb begin
    sel_valid = ctl_pend_q || pick_any;
    sel_unit  = ctl_pend_q ? ctl_unit_q : pick_idx;
  end

  rwint_resp_fmt #(.N(N), .UW(UW)) u_fmt (
    .sel_valid(sel_valid), .sel_is_dev(!ctl_pend_q), .sel_unit(sel_unit),
    .status_all(dev_status), .resp_d(resp_d)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      resp_q       <= '0;
      resp_valid_q <= 1'b0;
      bot_q        <= '0;
      cancel_q     <= '0;
    end else begin
      if (ack) resp_q <= resp_d;
      resp_valid_q <= ack;
      bot_q        <= rew_done & ~halt_dec;
      cancel_q     <= halt_dec;
    end
  end

  assign irq_pend   = ctl_pend_q | (|rew_pend);
  assign resp       = resp_q;
  assign resp_valid = resp_valid_q;
  assign bot_set    = bot_q;
  assign rew_cancel = cancel_q;
endmodule

// File: rtl/rwint_checker.sv
module rwint_checker #(
  parameter int N = 8,
  parameter int UW = 3,
  parameter int RESP_W = 11
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [N-1:0]      rew_done,
  input logic [N-1:0]      rew_irq_want,
  input logic              ack,
  input logic              halt,
  input logic [UW-1:0]     halt_unit,
  input logic              ctl_irq_set,
  input logic [N-1:0]      rew_pend,
  input logic              ctl_pend_q,
  input logic              irq_pend,
  input logic [RESP_W-1:0] resp,
  input logic              resp_valid,
  input logic [N-1:0]      bot_set
);
  p_ack_valid_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    ack |=> resp_valid);
  p_no_spurious_valid_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ack |=> !resp_valid);
  p_ctl_first_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ack && ctl_pend_q) |=> !resp[6]);
  p_dev_flag_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ack && !ctl_pend_q && (|rew_pend)) |=> resp[6]);
  p_low_bits_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    resp[2:0] == 3'b000);
  p_empty_zero_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ack && !irq_pend) |=> (resp == '0));
  p_halt_clears_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    halt |=> !rew_pend[$past(halt_unit)]);
  p_line_holds_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_pend && !ack && !halt) |=> irq_pend);
  p_set_raises_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|(rew_done & rew_irq_want) && !halt) |=> irq_pend);
  p_bot_origin_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|bot_set) |-> ((bot_set & ~$past(rew_done)) == '0));
  p_ctl_raises_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctl_irq_set |=> ctl_pend_q);
endmodule

bind rwint_arbiter rwint_checker #(.N(N), .UW(UW), .RESP_W(RESP_W)) u_rwint_chk (
  .clk(clk), .rst_int_n(rst_int_n), .rew_done(rew_done),
  .rew_irq_want(rew_irq_want), .ack(ack), .halt(halt), .halt_unit(halt_unit),
  .ctl_irq_set(ctl_irq_set), .rew_pend(rew_pend), .ctl_pend_q(ctl_pend_q),
  .irq_pend(irq_pend), .resp(resp), .resp_valid(resp_valid), .bot_set(bot_set)
);

// File: tb/test_rwint_arbiter.sv
module test_rwint_arbiter;
  localparam int N = 8;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  rew_done, rew_irq_want;
  logic        ctl_irq_set, ack, halt;
  logic [2:0]  ctl_irq_unit, halt_unit;
  logic [63:0] dev_status;
  logic        irq_pend, resp_valid;
  logic [10:0] resp;
  logic [7:0]  bot_set, rew_cancel;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rwint_arbiter i_rwint_arbiter (
    .clk(clk), .rst_n(rst_n), .rew_done(rew_done), .rew_irq_want(rew_irq_want),
    .ctl_irq_set(ctl_irq_set), .ctl_irq_unit(ctl_irq_unit), .ack(ack),
    .halt(halt), .halt_unit(halt_unit), .dev_status(dev_status),
    .irq_pend(irq_pend), .resp(resp), .resp_valid(resp_valid),
    .bot_set(bot_set), .rew_cancel(rew_cancel)
  );

  function automatic logic [7:0] stat_of(input int u);
    return 8'hFF - 8'(u * 8'h13);
  endfunction

  function automatic logic [10:0] exp_resp(input int u, input bit dev);
    logic [7:0] s;
    s = stat_of(u) & 8'hB8;
    if (dev) s = s | 8'h40;
    return {3'(u), s};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rew_done = '0; rew_irq_want = '0; ctl_irq_set = 0; ctl_irq_unit = '0;
    ack = 0; halt = 0; halt_unit = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rew_pulse(input int u, input bit want);
    rew_done[u] = 1; rew_irq_want[u] = want;
    @(negedge clk);
    rew_done = '0; rew_irq_want = '0;
  endtask

  task automatic ack_pulse(output logic [10:0] r, output logic v);
    ack = 1;
    @(negedge clk);
    ack = 0;
    r = resp; v = resp_valid;
  endtask

  task automatic test_reset();
    do_reset();
    check("R1 irq", 32'(irq_pend), 0);
    check("R1 resp", 32'(resp), 0);
    check("R1 valid/bot/cancel", {resp_valid, bot_set, rew_cancel}, 0);
  endtask

  task automatic test_no_want();
    rew_pulse(2, 0);
    check("R2 bot pulse", 32'(bot_set), 32'h04);
    check("R2 no pending without want", 32'(irq_pend), 0);
    @(negedge clk);
    check("R2 bot one cycle", 32'(bot_set), 0);
  endtask

  task automatic test_want();
    logic [10:0] r; logic v;
    rew_pulse(5, 1);
    check("R2 bot unit5", 32'(bot_set), 32'h20);
    check("R3 irq rises", 32'(irq_pend), 1);
    ack_pulse(r, v);
    check("R4 valid", 32'(v), 1);
    check("R6 R7 resp unit5", 32'(r), 32'(exp_resp(5, 1)));
    check("R3 irq drops", 32'(irq_pend), 0);
    @(negedge clk);
    check("R4 valid one cycle", 32'(resp_valid), 0);
    check("R4 resp held", 32'(resp), 32'(exp_resp(5, 1)));
  endtask

  task automatic test_order();
    logic [10:0] r; logic v;
    rew_pulse(6, 1); rew_pulse(1, 1); rew_pulse(3, 1);
    ack_pulse(r, v);
    check("R6 first lowest 1", 32'(r), 32'(exp_resp(1, 1)));
    check("R3 still pending", 32'(irq_pend), 1);
    ack_pulse(r, v);
    check("R6 then 3", 32'(r), 32'(exp_resp(3, 1)));
    ack_pulse(r, v);
    check("R6 then 6", 32'(r), 32'(exp_resp(6, 1)));
    check("R3 empty", 32'(irq_pend), 0);
  endtask

  task automatic test_ctl_priority();
    logic [10:0] r; logic v;
    rew_pulse(4, 1);
    ctl_irq_set = 1; ctl_irq_unit = 3'd7;
    @(negedge clk);
    ctl_irq_set = 0;
    ack_pulse(r, v);
    check("R5 ctl served first", 32'(r), 32'(exp_resp(7, 0)));
    check("R3 reasserted with rewind left", 32'(irq_pend), 1);
    ack_pulse(r, v);
    check("R6 rewind after ctl", 32'(r), 32'(exp_resp(4, 1)));
    check("R3 low", 32'(irq_pend), 0);
  endtask

  task automatic test_empty_ack();
    logic [10:0] r; logic v;
    ack_pulse(r, v);
    check("R8 valid", 32'(v), 1);
    check("R8 zero resp", 32'(r), 0);
  endtask

  task automatic test_halt();
    logic [10:0] r; logic v;
    rew_pulse(2, 1); rew_pulse(3, 1);
    halt = 1; halt_unit = 3'd2;
    @(negedge clk);
    halt = 0;
    check("R9 cancel pulse", 32'(rew_cancel), 32'h04);
    ack_pulse(r, v);
    check("R9 unit2 gone", 32'(r), 32'(exp_resp(3, 1)));
    ack_pulse(r, v);
    check("R9 nothing left", 32'(r), 0);
    ctl_irq_set = 1; ctl_irq_unit = 3'd1;
    @(negedge clk);
    ctl_irq_set = 0;
    check("R5 ctl raises", 32'(irq_pend), 1);
    halt = 1; halt_unit = 3'd1;
    @(negedge clk);
    halt = 0;
    check("R9 halt clears ctl", 32'(irq_pend), 0);
  endtask

  task automatic test_collide();
    logic [10:0] r; logic v;
    halt = 1; halt_unit = 3'd5; rew_done[5] = 1; rew_irq_want[5] = 1;
    @(negedge clk);
    halt = 0; rew_done = '0; rew_irq_want = '0;
    check("R10 halt beats rewind irq", 32'(irq_pend), 0);
    check("R10 halt beats bot", 32'(bot_set), 0);
    ack_pulse(r, v);
    check("R10 nothing after collision", 32'(r), 0);
    rew_pulse(0, 1);
    ack = 1; rew_done[0] = 1; rew_irq_want[0] = 1;
    @(negedge clk);
    ack = 0; rew_done = '0; rew_irq_want = '0;
    check("R10 served unit0", 32'(resp), 32'(exp_resp(0, 1)));
    check("R10 new set survives ack", 32'(irq_pend), 1);
    ack_pulse(r, v);
    check("R10 unit0 again", 32'(r), 32'(exp_resp(0, 1)));
    check("R3 clear", 32'(irq_pend), 0);
  endtask

  task automatic test_mid_reset();
    rew_pulse(7, 1);
    check("R3 set before reset", 32'(irq_pend), 1);
    rst_n = 0;
    #1;
    check("R1 async drop", 32'(irq_pend), 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 still clear", 32'(irq_pend), 0);
  endtask

  initial begin
    rst_n = 0;
    idle_inputs();
    for (int u = 0; u < N; u++) dev_status[u*8 +: 8] = stat_of(u);
    test_reset();
    test_no_want();
    test_want();
    test_order();
    test_ctl_priority();
    test_empty_ack();
    test_halt();
    test_collide();
    test_mid_reset();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule